// File: doc/BRIEF.md
# Masked internal control register file

This block holds a bank of 64-bit internal control registers that a processor's privileged code reaches through one access port. An access carries an enable, a direction, a 6-bit index and 64 bits of write data. Reads return data in the same cycle, and writes take effect on the next clock edge. Each register follows its own rule. Some take a full write. Some keep only the bits of a fixed mask. Two clear themselves on any write. One is read-only. Three invalidation registers turn a write into a one-cycle control pulse for translation buffers that sit outside this block.

A cycle-count register returns its stored upper half joined to the low 32 bits of a free-running counter. A speculation input makes every write disappear without a fault. This lets wrong-path instructions touch the port safely. An access to an index with no register raises a fault.

Top module: `ctl_reg_file`

## Requirements
- R1: After reset every register reads zero, except the base register (index 4), which reads the parameter BASE_RST.
- R2: The scratch registers (indices 0 to 3) and the base register (index 4) store all 64 written bits. A read returns them in the same cycle with no fault.
- R3: A write to the exception-return register (index 5) stores the data with bit 1 forced to zero.
- R4: Masked writes keep only these bits: trap request (index 6) and trap enable (index 7) keep mask 0xF, priority level (index 8) keeps 0x1F, processor mode (index 9) keeps 0x18, and software request (index 10) keeps 0x7FFF0.
- R5: Any write to the error summary (index 11) or the error mask (index 12) leaves that register zero, whatever the data.
- R6: A write to the level-ID register (index 13) raises fault in that cycle and does not change the register, which still reads zero.
- R7: A read of invalidate-all (15), invalidate-process (16) or invalidate-single (17) returns zero and raises fault.
- R8: A read of the cycle register (index 14) returns the written upper 32 bits and, in the low 32 bits, a counter that advances by one per clock.
- R9: A write to index 15 or 16 raises flush_all or flush_proc for exactly the cycle after the write edge. A write to index 17 raises flush_one in that cycle, with flush_addr equal to the written data. Only one pulse is high at a time.
- R10: While spec_i is high, a write changes no register, raises no fault and produces no pulse.
- R11: An access to an index of 18 or above raises fault, and a read of such an index returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_idx | input | 6 | Register index |
| acc_wdata | input | 64 | Write data |
| spec_i | input | 1 | Misspeculation: suppress writes |
| rd_data | output | 64 | Read data (combinational) |
| fault | output | 1 | Illegal access in this cycle |
| flush_all | output | 1 | Invalidate-all pulse |
| flush_proc | output | 1 | Invalidate-process pulse |
| flush_one | output | 1 | Invalidate-single pulse |
| flush_addr | output | 64 | Value of the last invalidate-single write |

## Verification
The assertions assume that acc_idx, acc_wr and spec_i hold steady for the whole cycle in which acc_en is high. They also assume that a fault or pulse is judged only when acc_en is high. The stimulus meets this by changing every input only on the falling edge and by dropping acc_en between accesses. The bench also sends speculative writes to writable, pulsing and undefined indices. This exercises the rule that no fault is raised under speculation, and the stimulus never expects one there.

// File: rtl/ctl_regs_pkg.sv
package ctl_regs_pkg;
    localparam int DW     = 64;
    localparam int HALF   = DW / 2;
    localparam int IDX_W  = 6;
    localparam int NUM_SCR = 4;
    localparam int NREG   = 18;
    localparam int SLOT_W = $clog2(NREG);

    localparam int IX_BASE     = NUM_SCR;
    localparam int IX_EXC_RET  = NUM_SCR + 1;
    localparam int IX_TRAP_REQ = NUM_SCR + 2;
    localparam int IX_TRAP_EN  = NUM_SCR + 3;
    localparam int IX_PRIO     = NUM_SCR + 4;
    localparam int IX_MODE     = NUM_SCR + 5;
    localparam int IX_SWREQ    = NUM_SCR + 6;
    localparam int IX_ERR_SUM  = NUM_SCR + 7;
    localparam int IX_ERR_MSK  = NUM_SCR + 8;
    localparam int IX_LVL_ID   = NUM_SCR + 9;
    localparam int IX_CYC      = NUM_SCR + 10;
    localparam int IX_INV_ALL  = NUM_SCR + 11;
    localparam int IX_INV_PROC = NUM_SCR + 12;
    localparam int IX_INV_ONE  = NUM_SCR + 13;

    typedef enum logic [2:0] {
        K_NONE, K_MASK, K_CLEAR, K_RO, K_WO_ZERO, K_WO_KEEP, K_CYC
    } kind_e;

    typedef enum logic [1:0] {P_NONE, P_ALL, P_PROC, P_ONE} pulse_e;

    typedef struct packed {
        logic [NREG-1:0][DW-1:0] regs;
        logic                    fl_all;
        logic                    fl_proc;
        logic                    fl_one;
    } state_t;
endpackage

// File: rtl/ctl_reg_decode.sv
module ctl_reg_decode
    import ctl_regs_pkg::*;
(
    input  logic [IDX_W-1:0] idx,
    output kind_e            kind,
    output logic [DW-1:0]    wmask,
    output pulse_e           pulse
);
    always_comb begin
        kind  = K_NONE;
        wmask = '1;
        pulse = P_NONE;
        if (int'(idx) <= IX_BASE) begin
            kind = K_MASK;
        end else begin
            case (int'(idx))
                IX_EXC_RET:  begin kind = K_MASK; wmask = ~(DW'(2)); end
                IX_TRAP_REQ,
                IX_TRAP_EN:  begin kind = K_MASK; wmask = DW'(4'hF); end
                IX_PRIO:     begin kind = K_MASK; wmask = DW'(5'h1F); end
                IX_MODE:     begin kind = K_MASK; wmask = DW'(8'h18); end
                IX_SWREQ:    begin kind = K_MASK; wmask = DW'(20'h7FFF0); end
                IX_ERR_SUM,
                IX_ERR_MSK:  kind = K_CLEAR;
                IX_LVL_ID:   kind = K_RO;
                IX_CYC:      kind = K_CYC;
                IX_INV_ALL:  begin kind = K_WO_ZERO; pulse = P_ALL; end
                IX_INV_PROC: begin kind = K_WO_ZERO; pulse = P_PROC; end
                IX_INV_ONE:  begin kind = K_WO_KEEP; pulse = P_ONE; end
                default:     kind = K_NONE;
            endcase
        end
    end
endmodule

// File: rtl/ctl_cycle_ctr.sv
module ctl_cycle_ctr #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] count
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb cnt_d = cnt_q + W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/ctl_reg_file.sv
module ctl_reg_file
    import ctl_regs_pkg::*;
#(
    parameter logic [63:0] BASE_RST = 64'h0000_0000_0001_0000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        acc_en,
    input  logic        acc_wr,
    input  logic [5:0]  acc_idx,
    input  logic [63:0] acc_wdata,
    input  logic        spec_i,
    output logic [63:0] rd_data,
    output logic        fault,
    output logic        flush_all,
    output logic        flush_proc,
    output logic        flush_one,
    output logic [63:0] flush_addr
);
    kind_e             kind;
    logic [DW-1:0]     wmask;
    pulse_e            pulse;
    logic [HALF-1:0]   cyc_cnt;
    logic [SLOT_W-1:0] slot;
    state_t            st_d, st_q;

    ctl_reg_decode u_dec (
        .idx   (acc_idx),
        .kind  (kind),
        .wmask (wmask),
        .pulse (pulse)
    );

    ctl_cycle_ctr #(.W(HALF)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .count (cyc_cnt)
    );

    assign slot = acc_idx[SLOT_W-1:0];

    always_comb begin
        st_d         = st_q;
        st_d.fl_all  = 1'b0;
        st_d.fl_proc = 1'b0;
        st_d.fl_one  = 1'b0;
        rd_data      = '0;
        fault        = 1'b0;
        if (acc_en) begin
            if (!acc_wr) begin
                case (kind)
                    K_NONE, K_WO_ZERO, K_WO_KEEP: fault = 1'b1;
                    K_CYC:   rd_data = {st_q.regs[slot][DW-1:HALF], cyc_cnt};
                    default: rd_data = st_q.regs[slot];
                endcase
            end else if (!spec_i) begin
                case (kind)
                    K_NONE, K_RO: fault = 1'b1;
                    K_MASK:       st_d.regs[slot] = acc_wdata & wmask;
                    K_CLEAR,
                    K_WO_ZERO:    st_d.regs[slot] = '0;
                    K_CYC,
                    K_WO_KEEP:    st_d.regs[slot] = acc_wdata;
                    default:      fault = 1'b1;
                endcase
                st_d.fl_all  = (pulse == P_ALL);
                st_d.fl_proc = (pulse == P_PROC);
                st_d.fl_one  = (pulse == P_ONE);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q               <= '0;
            st_q.regs[IX_BASE] <= BASE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign flush_all  = st_q.fl_all;
    assign flush_proc = st_q.fl_proc;
    assign flush_one  = st_q.fl_one;
    assign flush_addr = st_q.regs[IX_INV_ONE];
endmodule

// File: rtl/ctl_reg_file_chk.sv
module ctl_reg_file_chk
    import ctl_regs_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        acc_en,
    input logic        acc_wr,
    input logic [5:0]  acc_idx,
    input logic        spec_i,
    input logic [63:0] rd_data,
    input logic        fault,
    input logic        flush_all,
    input logic        flush_proc,
    input logic        flush_one
);
    logic wr_live;
    logic rd_wo;
    assign wr_live = acc_en && acc_wr && !spec_i;
    assign rd_wo   = acc_en && !acc_wr && (int'(acc_idx) >= IX_INV_ALL) &&
                     (int'(acc_idx) <= IX_INV_ONE);

    p_spec_no_fault_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && spec_i) |-> !fault);

    p_spec_no_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_wr && spec_i) |=> !(flush_all || flush_proc || flush_one));

    p_pulse_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flush_all, flush_proc, flush_one}));

    p_inv_all_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_live && int'(acc_idx) == IX_INV_ALL) |=> flush_all);

    p_wo_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_wo |-> (fault && rd_data == 64'd0));

    p_ro_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_live && int'(acc_idx) == IX_LVL_ID) |-> fault);

    p_undef_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && int'(acc_idx) >= NREG && !(acc_wr && spec_i)) |->
        (fault && rd_data == 64'd0));
endmodule

bind ctl_reg_file ctl_reg_file_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_en     (acc_en),
    .acc_wr     (acc_wr),
    .acc_idx    (acc_idx),
    .spec_i     (spec_i),
    .rd_data    (rd_data),
    .fault      (fault),
    .flush_all  (flush_all),
    .flush_proc (flush_proc),
    .flush_one  (flush_one)
);

// File: tb/ctl_reg_file_tb.sv
module ctl_reg_file_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [63:0] BASE_VAL = 64'h0000_0000_0001_0000;
    localparam int NV = 10;

    localparam logic [5:0] V_IDX [NV] = '{6'd0, 6'd3, 6'd4, 6'd5, 6'd5,
                                          6'd6, 6'd7, 6'd8, 6'd9, 6'd10};
    localparam logic [63:0] V_WD [NV] = '{
        64'hDEAD_BEEF_0123_4567, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0000,
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0003, 64'h0000_0000_0000_00FF,
        64'h0000_0000_0000_00A5, 64'h0000_0000_0000_FFFF, 64'h0000_0000_0000_00FF,
        64'hFFFF_FFFF_FFFF_FFFF};
    localparam logic [63:0] V_EXP [NV] = '{
        64'hDEAD_BEEF_0123_4567, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_8000_0000,
        64'hFFFF_FFFF_FFFF_FFFD, 64'h0000_0000_0000_0001, 64'h0000_0000_0000_000F,
        64'h0000_0000_0000_0005, 64'h0000_0000_0000_001F, 64'h0000_0000_0000_0018,
        64'h0000_0000_0007_FFF0};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_wr = 1'b0;
    logic [5:0]  acc_idx = '0;
    logic [63:0] acc_wdata = '0;
    logic        spec_i = 1'b0;
    logic [63:0] rd_data;
    logic        fault;
    logic        flush_all, flush_proc, flush_one;
    logic [63:0] flush_addr;

    int checks = 0;
    int errors = 0;
    logic [63:0] rv;
    logic        rf, wf;

    ctl_reg_file #(.BASE_RST(BASE_VAL)) u_dut (
        .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
        .acc_idx(acc_idx), .acc_wdata(acc_wdata), .spec_i(spec_i),
        .rd_data(rd_data), .fault(fault), .flush_all(flush_all),
        .flush_proc(flush_proc), .flush_one(flush_one), .flush_addr(flush_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] idx, input logic [63:0] d, input logic sp);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b1; acc_idx = idx; acc_wdata = d; spec_i = sp;
        #1 wf = fault;
        @(posedge clk);
        #1 acc_en = 1'b0; acc_wr = 1'b0; spec_i = 1'b0;
    endtask

    task automatic rd(input logic [5:0] idx);
        @(negedge clk);
        acc_en = 1'b1; acc_wr = 1'b0; acc_idx = idx;
        #1 rv = rd_data; rf = fault;
        acc_en = 1'b0;
    endtask

    function automatic string vtag(input int i);
        if (V_IDX[i] <= 6'd4) return "R2";
        if (V_IDX[i] == 6'd5) return "R3";
        return "R4";
    endfunction

    initial begin
        #(CLK_PERIOD * 50000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [63:0] lo1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset values
        rd(6'd0);  chk("R1 scratch0", rv, 64'd0);
        rd(6'd4);  chk("R1 base", rv, BASE_VAL);
        rd(6'd8);  chk("R1 prio", rv, 64'd0);
        chk("R1 no pulse", {61'd0, flush_all, flush_proc, flush_one}, 64'd0);

        // Vector table: R2, R3, R4
        for (int i = 0; i < NV; i++) begin
            wr(V_IDX[i], V_WD[i], 1'b0);
            chk({vtag(i), " write fault"}, {63'd0, wf}, 64'd0);
            rd(V_IDX[i]);
            chk({vtag(i), " readback"}, rv, V_EXP[i]);
            chk({vtag(i), " read fault"}, {63'd0, rf}, 64'd0);
        end

        // R5 write-to-clear
        wr(6'd11, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0);
        rd(6'd11); chk("R5 err summary", rv, 64'd0);
        wr(6'd12, 64'h1234_5678_9ABC_DEF0, 1'b0);
        rd(6'd12); chk("R5 err mask", rv, 64'd0);

        // R6 read-only
        wr(6'd13, 64'hFFFF_0000_FFFF_0000, 1'b0);
        chk("R6 write fault", {63'd0, wf}, 64'd1);
        rd(6'd13); chk("R6 unchanged", rv, 64'd0);
        chk("R6 read no fault", {63'd0, rf}, 64'd0);

        // R9 invalidate pulses
        wr(6'd15, 64'hAAAA, 1'b0);
        chk("R9 flush_all", {61'd0, flush_all, flush_proc, flush_one}, 64'd4);
        @(posedge clk); #1
        chk("R9 flush_all single", {61'd0, flush_all, flush_proc, flush_one}, 64'd0);
        wr(6'd16, 64'h5555, 1'b0);
        chk("R9 flush_proc", {61'd0, flush_all, flush_proc, flush_one}, 64'd2);
        wr(6'd17, 64'h0000_1234_5678_9000, 1'b0);
        chk("R9 flush_one", {61'd0, flush_all, flush_proc, flush_one}, 64'd1);
        chk("R9 flush_addr", flush_addr, 64'h0000_1234_5678_9000);

        // R7 write-only reads
        rd(6'd15); chk("R7 inv_all data", rv, 64'd0); chk("R7 inv_all fault", {63'd0, rf}, 64'd1);
        rd(6'd16); chk("R7 inv_proc fault", {63'd0, rf}, 64'd1);
        rd(6'd17); chk("R7 inv_one data", rv, 64'd0); chk("R7 inv_one fault", {63'd0, rf}, 64'd1);

        // R8 cycle register
        wr(6'd14, 64'hCAFE_F00D_FFFF_FFFF, 1'b0);
        rd(6'd14); lo1 = rv;
        chk("R8 upper", {32'd0, rv[63:32]}, 64'hCAFE_F00D);
        repeat (5) @(posedge clk);
        rd(6'd14);
        chk("R8 counter step", {32'd0, rv[31:0]}, {32'd0, lo1[31:0] + 32'd5});

        // R10 speculation
        wr(6'd1, 64'h1111_2222_3333_4444, 1'b1);
        chk("R10 no fault", {63'd0, wf}, 64'd0);
        rd(6'd1); chk("R10 no change", rv, 64'd0);
        wr(6'd15, 64'd0, 1'b1);
        chk("R10 no pulse", {61'd0, flush_all, flush_proc, flush_one}, 64'd0);
        wr(6'd13, 64'hF, 1'b1);
        chk("R10 ro no fault", {63'd0, wf}, 64'd0);
        wr(6'd63, 64'hF, 1'b1);
        chk("R10 undef no fault", {63'd0, wf}, 64'd0);

        // R11 undefined indices
        rd(6'd40); chk("R11 read data", rv, 64'd0); chk("R11 read fault", {63'd0, rf}, 64'd1);
        wr(6'd18, 64'hFF, 1'b0);
        chk("R11 write fault", {63'd0, wf}, 64'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule